// File: doc/BRIEF.md
# Accelerator Translation Cache with Per-Direction Last-Page Registers

This block translates virtual page numbers to physical page numbers for an accelerator's DMA engine. It holds a small, fully associative set of translations. Two single-entry registers sit in front of that set. One remembers the page of the last translated read, and the other remembers the page of the last translated write. A request whose page equals the remembered page for its own direction is answered one cycle after it is accepted, and the associative set is not searched. Any other request is searched in the associative set and answered two cycles after it is accepted.

When the associative set holds no matching page, the block sends one request to a next-level translation port (a shared translation cache or a page walker). It waits for the reply and then passes the reply back to the requester. A successful reply is installed in the set at a round-robin slot, and it also becomes the remembered page for the requesting direction. A reply flagged as a fault is returned but is not stored. Reads and writes share the associative set, so they can evict each other's entries. The per-direction registers keep a streaming access pattern fast even when its entry has been pushed out of the set. A flush input clears everything. Three counters give the number of responses of each kind.

Top module: `xlate_cache`

## Requirements
- R1: Out of reset, req_ready is 1, rsp_valid is 0, nl_req_valid is 0, and all three counters are 0.
- R2: A request whose direction's last-page register is valid and equal to req_vpn gets rsp_valid one cycle after acceptance. That response carries the stored ppn with rsp_fault 0. req_ready stays 1 in the response cycle, and no next-level request is made.
- R3: The read register (req_write=0) and the write register (req_write=1) are independent. A write to a page last seen only by reads is not answered by the read register.
- R4: A request that misses its direction's register but matches a valid set entry gets rsp_valid two cycles after acceptance, with that entry's ppn and rsp_fault 0. The matching page then becomes the register value for that direction.
- R5: A request that matches neither its direction's register nor a set entry raises nl_req_valid with nl_req_vpn equal to its page. Both are held until nl_req_ready. Only one such request is outstanding at a time, and req_ready is 0 until the reply. The response returns nl_rsp_ppn and nl_rsp_fault, at least three cycles after acceptance.
- R6: Successful refills fill slots 0,1,…,ENTRIES-1 in order and then wrap to slot 0, evicting the oldest refill. No page is held in two slots.
- R7: A reply with nl_rsp_fault=1 is returned with rsp_fault=1. It installs nothing and updates no register, so the same request misses again.
- R8: While flush is 1, req_ready is 0. The flush cycle invalidates every set entry and both registers, and returns the round-robin slot to 0.
- R9: cnt_filt, cnt_tlb and cnt_miss each rise by one on the response of a register hit, a set hit and a next-level reply respectively (fault replies count as misses). They are not cleared by flush.
- R10: A register hit is served even after the entry for that page has been evicted from the set by traffic in the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all translations |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vpn | input | VPN_W | Virtual page number |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ppn | output | PPN_W | Physical page number |
| rsp_fault | output | 1 | Translation fault |
| nl_req_valid | output | 1 | Next-level request |
| nl_req_ready | input | 1 | Next level accepts request |
| nl_req_vpn | output | VPN_W | Page sent to next level |
| nl_rsp_valid | input | 1 | Next-level reply strobe |
| nl_rsp_ppn | input | PPN_W | Reply physical page |
| nl_rsp_fault | input | 1 | Reply fault flag |
| cnt_filt | output | CNT_W | Register-hit count |
| cnt_tlb | output | CNT_W | Set-hit count |
| cnt_miss | output | CNT_W | Next-level reply count |

## Verification
The bench builds the block with four set entries, 12-bit virtual pages, 10-bit physical pages and 12-bit counters. At this size, five distinct pages are enough to force a round-robin wrap and an eviction. A few hundred pseudo-random requests over seven pages plus one faulting page, in both directions, therefore reach every response kind many times. Those requests also exercise cross-direction eviction under a still-valid register. Directed sequences pin down the wrap order, direction separation, register survival after eviction, fault non-install and flush, with exact latency checked for register and set hits.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOK   = 2'd1,
        ST_NLREQ  = 2'd2,
        ST_NLWAIT = 2'd3
    } xc_state_e;

    localparam int DIRS = 2;

    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/tlbf_filter.sv
module tlbf_filter #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  logic [VPN_W-1:0] upd_vpn,
    input  logic [PPN_W-1:0] upd_ppn,
    input  logic [VPN_W-1:0] q_vpn,
    output logic             match,
    output logic [PPN_W-1:0] ppn
);
    logic             v_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            v_q   <= 1'b0;
            vpn_q <= '0;
            ppn_q <= '0;
        end else if (upd) begin
            v_q   <= 1'b1;
            vpn_q <= upd_vpn;
            ppn_q <= upd_ppn;
        end
    end

    assign match = v_q && (vpn_q == q_vpn);
    assign ppn   = ppn_q;
endmodule

// File: rtl/tlbf_cam.sv
module tlbf_cam
    import tlbf_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [VPN_W-1:0]   look_vpn,
    output logic               hit,
    output logic [PPN_W-1:0]   hit_ppn,
    output logic [ENTRIES-1:0] hit_vec,
    input  logic               fill,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [IDX_W-1:0]   rr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (fill) begin
            valid_q[rr_q] <= 1'b1;
            rr_q          <= IDX_W'(wrap_inc(int'(rr_q), ENTRIES));
        end
    end

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst) begin
                    vpn_q[i] <= '0;
                    ppn_q[i] <= '0;
                end else if (fill && !clr && rr_q == IDX_W'(i)) begin
                    vpn_q[i] <= fill_vpn;
                    ppn_q[i] <= fill_ppn;
                end
            end
            assign hit_vec[i] = valid_q[i] && (vpn_q[i] == look_vpn);
        end
    endgenerate

    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_ppn = hit_ppn | ppn_q[i];
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import tlbf_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 16,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             rsp_valid,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             rsp_fault,
    output logic             nl_req_valid,
    input  logic             nl_req_ready,
    output logic [VPN_W-1:0] nl_req_vpn,
    input  logic             nl_rsp_valid,
    input  logic [PPN_W-1:0] nl_rsp_ppn,
    input  logic             nl_rsp_fault,
    output logic [CNT_W-1:0] cnt_filt,
    output logic [CNT_W-1:0] cnt_tlb,
    output logic [CNT_W-1:0] cnt_miss
);
    xc_state_e          state_q;
    logic               cur_write_q;
    logic [VPN_W-1:0]   cur_vpn_q;

    logic [DIRS-1:0]    f_match;
    logic [PPN_W-1:0]   f_ppn [DIRS];
    logic [DIRS-1:0]    f_upd;
    logic [PPN_W-1:0]   f_upd_ppn;

    logic               cam_hit;
    logic [PPN_W-1:0]   cam_ppn;
    logic [ENTRIES-1:0] cam_hit_vec;
    logic               refill_ok;
    logic               look_hit;
    logic               accept;

    assign req_ready    = (state_q == ST_IDLE) && !flush;
    assign accept       = req_valid && req_ready;
    assign nl_req_valid = (state_q == ST_NLREQ);
    assign nl_req_vpn   = cur_vpn_q;
    assign look_hit     = (state_q == ST_LOOK) && cam_hit;
    assign refill_ok    = (state_q == ST_NLWAIT) && nl_rsp_valid && !nl_rsp_fault;
    assign f_upd_ppn    = look_hit ? cam_ppn : nl_rsp_ppn;

    generate
        for (genvar d = 0; d < DIRS; d++) begin : g_dir
            assign f_upd[d] = (look_hit || refill_ok) && (cur_write_q == d[0]);
            tlbf_filter #(.VPN_W(VPN_W), .PPN_W(PPN_W)) i_filt (
                .clk     (clk),
                .rst     (rst),
                .clr     (flush),
                .upd     (f_upd[d]),
                .upd_vpn (cur_vpn_q),
                .upd_ppn (f_upd_ppn),
                .q_vpn   (req_vpn),
                .match   (f_match[d]),
                .ppn     (f_ppn[d])
            );
        end
    endgenerate

    tlbf_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_cam (
        .clk      (clk),
        .rst      (rst),
        .clr      (flush),
        .look_vpn (cur_vpn_q),
        .hit      (cam_hit),
        .hit_ppn  (cam_ppn),
        .hit_vec  (cam_hit_vec),
        .fill     (refill_ok),
        .fill_vpn (cur_vpn_q),
        .fill_ppn (nl_rsp_ppn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cur_write_q <= 1'b0;
            cur_vpn_q   <= '0;
            rsp_valid   <= 1'b0;
            rsp_ppn     <= '0;
            rsp_fault   <= 1'b0;
            cnt_filt    <= '0;
            cnt_tlb     <= '0;
            cnt_miss    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cur_write_q <= req_write;
                        cur_vpn_q   <= req_vpn;
                        if (f_match[req_write]) begin
                            rsp_valid <= 1'b1;
                            rsp_ppn   <= f_ppn[req_write];
                            rsp_fault <= 1'b0;
                            cnt_filt  <= cnt_filt + 1'b1;
                        end else begin
                            state_q <= ST_LOOK;
                        end
                    end
                end
                ST_LOOK: begin
                    if (cam_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_ppn   <= cam_ppn;
                        rsp_fault <= 1'b0;
                        cnt_tlb   <= cnt_tlb + 1'b1;
                        state_q   <= ST_IDLE;
                    end else begin
                        state_q <= ST_NLREQ;
                    end
                end
                ST_NLREQ: begin
                    if (nl_req_ready) state_q <= ST_NLWAIT;
                end
                ST_NLWAIT: begin
                    if (nl_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_ppn   <= nl_rsp_ppn;
                        rsp_fault <= nl_rsp_fault;
                        cnt_miss  <= cnt_miss + 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tlbf_chk.sv
module tlbf_chk #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               rsp_fault,
    input logic               nl_req_valid,
    input logic               nl_req_ready,
    input logic [VPN_W-1:0]   nl_req_vpn,
    input logic [CNT_W-1:0]   cnt_filt,
    input logic [CNT_W-1:0]   cnt_tlb,
    input logic [CNT_W-1:0]   cnt_miss,
    input logic [ENTRIES-1:0] cam_hit_vec
);
    logic [CNT_W-1:0] tot;
    assign tot = cnt_filt + cnt_tlb + cnt_miss;

    // R5
    nl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        nl_req_valid && !nl_req_ready |=> nl_req_valid && $stable(nl_req_vpn));

    // R5
    nl_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
        nl_req_valid |-> !req_ready);

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        tot == $past(tot) + {{(CNT_W-1){1'b0}}, rsp_valid});

    // R7
    fault_is_miss_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> cnt_miss == $past(cnt_miss) + 1'b1);

    // R6
    no_dup_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cam_hit_vec));
endmodule

bind xlate_cache tlbf_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .CNT_W(CNT_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .nl_req_valid (nl_req_valid),
    .nl_req_ready (nl_req_ready),
    .nl_req_vpn   (nl_req_vpn),
    .cnt_filt     (cnt_filt),
    .cnt_tlb      (cnt_tlb),
    .cnt_miss     (cnt_miss),
    .cam_hit_vec  (cam_hit_vec)
);

// File: tb/test_xlate_cache.sv
module test_xlate_cache;
    localparam int NE = 4;
    localparam int VW = 12;
    localparam int PW = 10;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [VW-1:0] req_vpn = '0;
    logic          rsp_valid;
    logic [PW-1:0] rsp_ppn;
    logic          rsp_fault;
    logic          nl_req_valid;
    logic          nl_req_ready = 1'b1;
    logic [VW-1:0] nl_req_vpn;
    logic          nl_rsp_valid = 1'b0;
    logic [PW-1:0] nl_rsp_ppn = '0;
    logic          nl_rsp_fault = 1'b0;
    logic [CW-1:0] cnt_filt, cnt_tlb, cnt_miss;

    xlate_cache #(.ENTRIES(NE), .VPN_W(VW), .PPN_W(PW), .CNT_W(CW)) i_xlate_cache (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_vpn(req_vpn),
        .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_fault(rsp_fault),
        .nl_req_valid(nl_req_valid), .nl_req_ready(nl_req_ready), .nl_req_vpn(nl_req_vpn),
        .nl_rsp_valid(nl_rsp_valid), .nl_rsp_ppn(nl_rsp_ppn), .nl_rsp_fault(nl_rsp_fault),
        .cnt_filt(cnt_filt), .cnt_tlb(cnt_tlb), .cnt_miss(cnt_miss)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int nl_seen = 0;

    // bench model
    bit          m_val [NE];
    logic [VW-1:0] m_vpn [NE];
    logic [PW-1:0] m_ppn [NE];
    int          m_rr = 0;
    bit          f_val [2];
    logic [VW-1:0] f_vpn [2];
    logic [PW-1:0] f_ppn [2];
    int          e_filt = 0, e_tlb = 0, e_miss = 0;

    function automatic logic [PW-1:0] map_ppn(input logic [VW-1:0] v);
        return PW'(v * 3 + 5);
    endfunction

    function automatic bit is_fault(input logic [VW-1:0] v);
        return v[3:0] == 4'hF;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_flush();
        for (int i = 0; i < NE; i++) m_val[i] = 0;
        m_rr = 0;
        f_val[0] = 0;
        f_val[1] = 0;
    endtask

    // 1 = register hit, 2 = set hit, 3 = miss
    task automatic do_req(input bit w, input logic [VW-1:0] v, input string tag);
        int kind;
        int lat;
        int hit_i;
        bit rdy_at_rsp;
        logic [PW-1:0] exp_ppn;
        bit exp_fault;
        int nl_before;
        exp_fault = 0;
        hit_i = -1;
        if (f_val[w] && f_vpn[w] == v) begin
            kind = 1;
            exp_ppn = f_ppn[w];
            e_filt++;
        end else begin
            for (int i = 0; i < NE; i++) if (m_val[i] && m_vpn[i] == v) hit_i = i;
            if (hit_i >= 0) begin
                kind = 2;
                exp_ppn = m_ppn[hit_i];
                f_val[w] = 1; f_vpn[w] = v; f_ppn[w] = exp_ppn;
                e_tlb++;
            end else begin
                kind = 3;
                exp_ppn = map_ppn(v);
                exp_fault = is_fault(v);
                e_miss++;
                if (!exp_fault) begin
                    m_val[m_rr] = 1; m_vpn[m_rr] = v; m_ppn[m_rr] = exp_ppn;
                    m_rr = (m_rr + 1) % NE;
                    f_val[w] = 1; f_vpn[w] = v; f_ppn[w] = exp_ppn;
                end
            end
        end
        nl_before = nl_seen;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_vpn = v;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        lat = 0;
        rdy_at_rsp = 0;
        forever begin
            @(negedge clk);
            if (lat == 0) req_valid = 1'b0;
            lat++;
            if (rsp_valid) begin
                rdy_at_rsp = req_ready;
                break;
            end
            if (lat > 40) break;
        end
        if (kind == 1) begin
            chk(lat == 1, {"R2 register-hit latency ", tag}, lat, 1);
            chk(rdy_at_rsp, {"R2 ready during response ", tag}, rdy_at_rsp, 1);
            chk(nl_seen == nl_before, {"R2 no next-level request ", tag}, nl_seen - nl_before, 0);
        end else if (kind == 2) begin
            chk(lat == 2, {"R4 set-hit latency ", tag}, lat, 2);
            chk(nl_seen == nl_before, {"R4 no next-level request ", tag}, nl_seen - nl_before, 0);
        end else begin
            chk(lat >= 3 && lat <= 40, {"R5 miss latency ", tag}, lat, 3);
            chk(nl_seen == nl_before + 1, {"R5 one next-level request ", tag}, nl_seen - nl_before, 1);
        end
        chk(rsp_ppn == exp_ppn, {"R2/R4/R5 ppn ", tag}, int'(rsp_ppn), int'(exp_ppn));
        chk(rsp_fault == exp_fault, {"R7 fault flag ", tag}, int'(rsp_fault), int'(exp_fault));
    endtask

    task automatic chk_counts(input string tag);
        chk(cnt_filt == CW'(e_filt), {"R9 cnt_filt ", tag}, int'(cnt_filt), e_filt);
        chk(cnt_tlb  == CW'(e_tlb),  {"R9 cnt_tlb ", tag},  int'(cnt_tlb),  e_tlb);
        chk(cnt_miss == CW'(e_miss), {"R9 cnt_miss ", tag}, int'(cnt_miss), e_miss);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        chk(!req_ready, "R8 ready low during flush", int'(req_ready), 0);
        flush = 1'b0;
        model_flush();
    endtask

    // next-level responder
    initial begin
        logic [VW-1:0] v;
        forever begin
            @(negedge clk);
            if (nl_req_valid) begin
                nl_seen++;
                v = nl_req_vpn;
                @(negedge clk);
                @(negedge clk);
                nl_rsp_valid = 1'b1;
                nl_rsp_ppn   = map_ppn(v);
                nl_rsp_fault = is_fault(v);
                @(negedge clk);
                nl_rsp_valid = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [2:0]  pg;
        model_flush();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        chk(nl_req_valid == 1'b0, "R1 nl_req_valid after reset", int'(nl_req_valid), 0);
        chk_counts("R1 reset");

        // R2 R4 R5: miss, then register hit, then other direction set hit (R3)
        do_req(0, 12'h101, "r miss");
        do_req(0, 12'h101, "r reg hit");
        do_req(1, 12'h101, "R3 w not served by read reg");
        do_req(1, 12'h101, "w reg hit");

        // R6: round-robin wrap with reads after flush
        do_flush();
        do_req(0, 12'h210, "R6 fill0");
        do_req(0, 12'h220, "R6 fill1");
        do_req(0, 12'h230, "R6 fill2");
        do_req(0, 12'h240, "R6 fill3");
        do_req(0, 12'h250, "R6 wrap evicts slot0");
        do_req(0, 12'h220, "R6 slot1 still held");
        do_req(0, 12'h210, "R6 evicted page misses");

        // R10: read register survives eviction by writes
        do_flush();
        do_req(0, 12'h301, "R10 read install");
        do_req(1, 12'h311, "R10 w fill");
        do_req(1, 12'h321, "R10 w fill");
        do_req(1, 12'h331, "R10 w fill");
        do_req(1, 12'h341, "R10 w evict");
        do_req(0, 12'h301, "R10 read reg after eviction");

        // R7: fault not installed
        do_req(1, 12'h00F, "R7 fault first");
        do_req(1, 12'h00F, "R7 fault again");
        do_req(1, 12'h341, "R7 write reg intact");

        // R8: flush clears registers and set
        do_flush();
        do_req(1, 12'h341, "R8 after flush");
        do_req(0, 12'h301, "R8 read after flush");
        chk_counts("R9 directed");

        // pseudo-random sweep over seven pages and one faulting page
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pg = lfsr[2:0];
            do_req(lfsr[5], {5'd0, pg, (pg == 3'd7) ? 4'hF : 4'h2}, "sweep");
            if (k == 200) do_flush();
        end
        chk_counts("R9 sweep");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule